// File: doc/BRIEF.md
# Auxiliary DAC Code Register Bank

This block holds the digital codes for a group of low-rate auxiliary voltage DACs. Software writes codes and control bits through a plain register write port of address, data and a one-cycle write strobe. Every channel keeps two registers. The staging register receives each code that is written. The active register feeds the converter. A global deferred-commit mode decides whether a code write reaches the active register at once, or only when a later write to the update register names that channel. With deferred commit, several channels can be loaded ahead of time and then switched together in a single cycle.

Each channel also has an inversion bit and a power-down bit. Inversion drives the bitwise complement of the active code. Power-down forces the driven code to zero and raises that channel's power-down output. Neither bit changes the stored codes. The write port has no back-pressure: it takes one write in every cycle in which the strobe is high.

Top module: `auxdac_bank`

## Requirements
- R1: After the asynchronous active-low reset, every driven code is 0x00, every power-down output is low, and deferred mode, inversion and power-down are all off.
- R2: A write to address 0, 1 or 2 loads the staging register of channel 0, 1 or 2 respectively. It never alters another channel's output.
- R3: When the mode register (address 4, bit 0) is 0, a code write drives the new code on the channel output in the cycle after the write's clock edge.
- R4: When mode bit 0 is 1, a code write leaves every driven output unchanged.
- R5: A write to the update register (address 3) copies the staging code of each channel whose bit (bit i for channel i) is 1 into its active register, with all flagged channels committed on the same edge. A channel whose bit is 0 keeps its output.
- R6: Writing the mode register never changes any output. Clearing deferred mode leaves pending staged codes uncommitted.
- R7: When bit i of the invert register (address 5) is 1, channel i drives the bitwise complement of its active code, so code 0x00 drives 0xFF.
- R8: When bit i of the power-down register (address 6) is 1, channel i drives 0x00 and its power-down output is high. Its staging and active codes are kept, and they reappear when the bit is cleared.
- R9: A write to address 7 has no effect on any output or stored state, and no cycle without a write strobe changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| dac_code_o | output | 24 | Driven codes, channel i in bits [8i+7:8i] |
| dac_pd_o | output | 3 | Power-down output, bit i for channel i |

## Verification
The assertions check four rules in every cycle. An output never moves without a write. Deferred code writes and mode writes leave outputs stable. An unflagged channel holds through an update write. A powered-down channel drives zero. Only the bench's scenarios can show the things that depend on stored history: a code staged under deferred mode and committed several writes later, pending codes that survive a mode change, values that reappear after power-down is released, and the exact code that inversion produces.

// File: rtl/auxdac_pkg.sv
package auxdac_pkg;
  // Strobes for the control-register writes.
  typedef struct packed {
    logic upd;
    logic mode;
    logic inv;
    logic pd;
  } ctl_we_t;
endpackage

// File: rtl/auxdac_decode.sv
module auxdac_decode
  import auxdac_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] code_we,
  output ctl_we_t           ctl_we
);
  localparam logic [ADDR_W-1:0] A_UPD  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(NUM_CH + 2);
  localparam logic [ADDR_W-1:0] A_PD   = ADDR_W'(NUM_CH + 3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_code
    assign code_we[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  always_comb begin
    ctl_we.upd  = wr_en && (wr_addr == A_UPD);
    ctl_we.mode = wr_en && (wr_addr == A_MODE);
    ctl_we.inv  = wr_en && (wr_addr == A_INV);
    ctl_we.pd   = wr_en && (wr_addr == A_PD);
  end
endmodule

// File: rtl/auxdac_ctrl.sv
module auxdac_ctrl
  import auxdac_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_we_t           ctl_we,
  input  logic [NUM_CH-1:0] flags,
  output logic              slave_q,
  output logic [NUM_CH-1:0] inv_q,
  output logic [NUM_CH-1:0] pd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= 1'b0;
      inv_q   <= '0;
      pd_q    <= '0;
    end else begin
      if (ctl_we.mode) slave_q <= flags[0];
      if (ctl_we.inv)  inv_q   <= flags;
      if (ctl_we.pd)   pd_q    <= flags;
    end
  end
endmodule

// File: rtl/auxdac_channel.sv
module auxdac_channel #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic              commit,
  input  logic              slave,
  input  logic              inv,
  input  logic              pd,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_o
);
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      if (code_we) stage_q <= wr_data;
      if (code_we && !slave) active_q <= wr_data;
      else if (commit)       active_q <= stage_q;
    end
  end

  always_comb begin
    if (pd)       code_o = '0;
    else if (inv) code_o = ~active_q;
    else          code_o = active_q;
    pd_o = pd;
  end
endmodule

// File: rtl/auxdac_bank.sv
module auxdac_bank
  import auxdac_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o,
  output logic [NUM_CH-1:0]        dac_pd_o
);
  logic [NUM_CH-1:0] code_we;
  ctl_we_t           ctl_we;
  logic              slave_q;
  logic [NUM_CH-1:0] inv_q;
  logic [NUM_CH-1:0] pd_q;

  auxdac_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .code_we (code_we),
    .ctl_we  (ctl_we)
  );

  auxdac_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (ctl_we),
    .flags   (wr_data[NUM_CH-1:0]),
    .slave_q (slave_q),
    .inv_q   (inv_q),
    .pd_q    (pd_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    auxdac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .code_we (code_we[i]),
      .commit  (ctl_we.upd && wr_data[i]),
      .slave   (slave_q),
      .inv     (inv_q[i]),
      .pd      (pd_q[i]),
      .wr_data (wr_data),
      .code_o  (dac_code_o[i*CODE_W +: CODE_W]),
      .pd_o    (dac_pd_o[i])
    );
  end
endmodule

// File: rtl/auxdac_bank_chk.sv
module auxdac_bank_chk #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [CODE_W-1:0]        wr_data,
  input logic [NUM_CH*CODE_W-1:0] dac_code_o,
  input logic [NUM_CH-1:0]        dac_pd_o,
  input logic                     slave_q,
  input logic [NUM_CH-1:0]        inv_q,
  input logic [NUM_CH-1:0]        pd_q
);
  localparam logic [ADDR_W-1:0] A_UPD  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_CH + 3);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dac_code_o) && $stable(dac_pd_o)));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_LAST) |=> ($stable(dac_code_o) && $stable(dac_pd_o)));

  p_deferred_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < A_UPD && slave_q) |=> $stable(dac_code_o));

  p_mode_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE) |=> $stable(dac_code_o));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i) && !slave_q && !inv_q[i] && !pd_q[i])
      |=> dac_code_o[i*CODE_W +: CODE_W] == $past(wr_data));

    p_unflagged_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_UPD && !wr_data[i])
      |=> $stable(dac_code_o[i*CODE_W +: CODE_W]));

    p_pd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dac_pd_o[i] |-> dac_code_o[i*CODE_W +: CODE_W] == '0);
  end
endmodule

bind auxdac_bank auxdac_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/auxdac_bank_test.sv
module auxdac_bank_test;
  localparam int NCH = 3;
  localparam int CW  = 8;
  localparam int AW  = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [AW-1:0]      wr_addr = '0;
  logic [CW-1:0]      wr_data = '0;
  logic [NCH*CW-1:0]  dac_code_o;
  logic [NCH-1:0]     dac_pd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state kept by the bench
  logic [CW-1:0]  m_stage [NCH];
  logic [CW-1:0]  m_act   [NCH];
  logic           m_slave;
  logic [NCH-1:0] m_inv;
  logic [NCH-1:0] m_pd;

  always #4 clk = ~clk;

  auxdac_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dac_code_o(dac_code_o), .dac_pd_o(dac_pd_o)
  );

  function automatic logic [CW-1:0] exp_code(int ch);
    if (m_pd[ch])  return '0;
    if (m_inv[ch]) return ~m_act[ch];
    return m_act[ch];
  endfunction

  function automatic string tag_for(logic [AW-1:0] a);
    if (a < NCH)     return m_slave ? "R4" : "R3";
    if (a == NCH)    return "R5";
    if (a == NCH+1)  return "R6";
    if (a == NCH+2)  return "R7";
    if (a == NCH+3)  return "R8";
    return "R9";
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [CW-1:0] d);
    if (a < NCH) begin
      m_stage[a] = d;
      if (!m_slave) m_act[a] = d;
    end else if (a == NCH) begin
      for (int i = 0; i < NCH; i++) if (d[i]) m_act[i] = m_stage[i];
    end else if (a == NCH+1) m_slave = d[0];
    else if (a == NCH+2) m_inv = d[NCH-1:0];
    else if (a == NCH+3) m_pd  = d[NCH-1:0];
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NCH; i++) begin
      checks++;
      if (dac_code_o[i*CW +: CW] !== exp_code(i)) begin
        errors++;
        $display("FAIL %s ch%0d code: actual=%02h expected=%02h",
                 tag, i, dac_code_o[i*CW +: CW], exp_code(i));
      end
    end
    checks++;
    if (dac_pd_o !== m_pd) begin
      errors++;
      $display("FAIL %s pd: actual=%b expected=%b", tag, dac_pd_o, m_pd);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [CW-1:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_act[i] = '0; end
    m_slave = 1'b0; m_inv = '0; m_pd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");

    // R3 / R2: immediate write to channel 1 only
    do_write(3'd1, 8'hA5, "R3 R2 immediate ch1");
    // R4: deferred mode, staged writes hold outputs
    do_write(3'd4, 8'h01, "R6 enter deferred");
    do_write(3'd0, 8'h3C, "R4 staged ch0");
    do_write(3'd2, 8'h81, "R4 staged ch2");
    // R5: selective commit
    do_write(3'd3, 8'h01, "R5 commit ch0 only");
    do_write(3'd3, 8'h04, "R5 commit ch2");
    // R6: leaving deferred mode does not commit
    do_write(3'd1, 8'h11, "R4 staged ch1");
    do_write(3'd4, 8'h00, "R6 leave deferred, no commit");
    do_write(3'd3, 8'h02, "R5 commit ch1 late");
    // R7: inversion
    do_write(3'd5, 8'h03, "R7 invert ch0 ch1");
    do_write(3'd0, 8'h00, "R7 code 00 drives FF");
    // R8: power-down keeps codes
    do_write(3'd6, 8'h04, "R8 power down ch2");
    do_write(3'd2, 8'h55, "R8 write while powered down");
    do_write(3'd6, 8'h00, "R8 release restores code");
    // R9: unmapped address and idle cycles
    do_write(3'd7, 8'hFF, "R9 unmapped write");
    repeat (4) @(negedge clk);
    check_all("R9 idle stable");
    // R5: all channels commit together
    do_write(3'd4, 8'h01, "R6 deferred again");
    do_write(3'd0, 8'h12, "R4 stage ch0");
    do_write(3'd1, 8'h34, "R4 stage ch1");
    do_write(3'd2, 8'h56, "R4 stage ch2");
    do_write(3'd3, 8'h07, "R5 commit all");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [CW-1:0] d;
      a = AW'($urandom % 8);
      d = CW'($urandom);
      do_write(a, d, tag_for(a));
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        check_all("R9 idle gap");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule